// File: doc/BRIEF.md
# Down-Counting Period Timer with Two PWM Outputs

The block is a down-counter that produces a periodic event and two pulse-width outputs. The counter is advanced by count ticks. A tick comes from one of three qualifying enables: a fast bus-rate enable, a slow low-power enable, or the underflow pulse of a neighbouring timer. A power-of-two prescaler sits between the enable and the tick. When the counter reaches zero and takes one more tick, it underflows. On underflow it reloads from the period register and raises a one-cycle pulse, which a system uses as its period interrupt or its wake-up event. Because the event fires on underflow, a period register value R produces R+1 ticks per period.

Two compare channels turn the count into waveforms. Each channel holds the low (start) phase for a programmed number of ticks and then switches to the opposite level for the rest of the period. A square-wave mode replaces both compare values with half the period. Software writes the period, the two duty values and a command word through one write port. The command word starts, stops or reloads the counter. Start and stop are passed through a fixed three-cycle arming delay before they act on the counter.

The run controller is a four-state machine:
- IDLE: stopped.
- ARM: a start is pending.
- RUN: counting.
- HALT: a stop is pending and counting continues.

Its transitions are:
- IDLE→ARM on a start command.
- ARM→RUN after three cycles.
- RUN→HALT on a stop command.
- HALT→IDLE after three cycles.

Top module: `dtmr_top`

## Requirements
- R1: While counting, every tick decrements the counter. A tick at count 0 instead reloads the period value and, one cycle later, shows a one-cycle `uf_evt` pulse. A period register value R therefore gives R+1 ticks between pulses, and R = 0 gives a pulse on every tick.
- R2: A period write (`wr_addr` = 0) loads the period and the counter at once, whether or not the timer runs. It also clears the prescaler.
- R3: A command write (`wr_addr` = 3) with `wr_data[2]` set reloads the counter from the period register at once and clears the prescaler.
- R4: Source select `src_sel` chooses the tick enable: 0 = `ce_bus`, 1 = `ce_slow`, 2 = `casc_in`, 3 = none. With `ce_bus`, `div_sel` 0 divides by 1, 1 divides by 2, and any other value divides by 8. With `ce_slow`, the division is 2^`div_sel` (1 to 128). With `casc_in`, the division is always 1.
- R5: With compare value C (duty A at `wr_addr` 1, duty B at 2), the channel's raw level is low for the first C ticks of a period and high for the rest. A one-cycle compare event marks the tick on which the raw level goes high.
- R6: C = 0 keeps the raw level high for the whole period. C ≥ R+1 keeps it low for the whole period. In both cases no compare event is raised.
- R7: A duty value written while counting, including one written on the underflow tick itself, becomes active at the next underflow after the write. A duty value written while the timer is stopped (IDLE, ARM) is active at once.
- R8: With `sq_mode` set, both channels use compare value (R+2)/2 (integer division). With P = R+1, the raw level is low for ceil(P/2) ticks and high for floor(P/2) ticks.
- R9: Pin mode encodings are 0 or 3 = pin held low, 1 = pin follows the raw level, 2 = pin is the inverse of the raw level. Outside RUN and HALT, the raw level is taken as low, so a mode-2 pin idles high.
- R10: A start command (`wr_data[0]`) in IDLE sets `sync_busy`, and `running` rises three cycles after the write edge. Counting begins one edge later. A stop command (`wr_data[1]`) in RUN sets `sync_busy`, and counting continues until `running` falls three cycles later. Commands that arrive while a transition is pending are ignored.
- R11: A period write or reload command on the same edge as an underflow tick takes priority. The counter takes the written or reloaded value and no `uf_evt` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 period, 1 duty A, 2 duty B, 3 command |
| wr_data | input | 16 | Write data; command bits 0 start, 1 stop, 2 reload |
| src_sel | input | 2 | Tick source select |
| div_sel | input | 3 | Prescaler exponent select |
| ce_bus | input | 1 | Fast bus-rate count enable |
| ce_slow | input | 1 | Slow low-power count enable |
| casc_in | input | 1 | Underflow pulse from the lower timer |
| sq_mode | input | 1 | Square-wave mode for both channels |
| mode_a | input | 2 | Output mode of pin A |
| mode_b | input | 2 | Output mode of pin B |
| pin_a | output | 1 | PWM output A |
| pin_b | output | 1 | PWM output B |
| uf_evt | output | 1 | Underflow (period) event |
| cmp_a_evt | output | 1 | Compare event A |
| cmp_b_evt | output | 1 | Compare event B |
| count | output | 16 | Current counter value |
| running | output | 1 | Counter is counting (RUN or HALT) |
| sync_busy | output | 1 | Start or stop is pending (ARM or HALT) |

## Verification
Three kinds of write can land on the same edge as the underflow tick: a period write, a reload command and a duty write. The bench counts from an observed underflow pulse and times the write so that the write port samples it on exactly the tick that would have underflowed. For period and reload writes, the result is judged by the absence of `uf_evt` in the next cycle, the counter value and the length of the following period. For duty writes, the high-time of the next two periods must show the old compare value first and the new one after that.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    typedef enum logic [1:0] {
        SRC_BUS  = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_CASC = 2'd2,
        SRC_NONE = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_LOW  = 2'd1,
        PM_HIGH = 2'd2,
        PM_OFF3 = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_HALT = 2'd3
    } run_st_e;

    localparam logic [1:0] ADR_PERIOD = 2'd0;
    localparam logic [1:0] ADR_DUTY_A = 2'd1;
    localparam logic [1:0] ADR_DUTY_B = 2'd2;
    localparam logic [1:0] ADR_CMD    = 2'd3;
endpackage

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
    import dtmr_pkg::*;
#(
    parameter int SYNC_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    output logic counting,
    output logic sync_busy
);
    localparam int SW = (SYNC_LAT > 1) ? $clog2(SYNC_LAT) : 1;
    localparam logic [SW-1:0] LAST = SW'(SYNC_LAT - 1);

    run_st_e       state, nxt;
    logic [SW-1:0] wait_q;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_req) nxt = ST_ARM;
            ST_ARM:  if (wait_q == LAST) nxt = ST_RUN;
            ST_RUN:  if (stop_req) nxt = ST_HALT;
            ST_HALT: if (wait_q == LAST) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register with the arming delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wait_q <= '0;
        end else begin
            state <= nxt;
            if ((nxt == state) && ((state == ST_ARM) || (state == ST_HALT)))
                wait_q <= wait_q + 1'b1;
            else
                wait_q <= '0;
        end
    end

    // outputs
    always_comb begin
        counting  = 1'b0;
        sync_busy = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ARM:  sync_busy = 1'b1;
            ST_RUN:  counting = 1'b1;
            ST_HALT: begin
                counting  = 1'b1;
                sync_busy = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dtmr_psc.sv
module dtmr_psc
    import dtmr_pkg::*;
#(
    parameter int PSC_W = 7,
    localparam int DW = $clog2(PSC_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    src_sel,
    input  logic [DW-1:0] div_sel,
    input  logic          ce_bus,
    input  logic          ce_slow,
    input  logic          casc_in,
    input  logic          run,
    input  logic          clr,
    output logic          tick
);
    logic             src_en;
    logic [DW-1:0]    expo;
    logic [PSC_W-1:0] mask;
    logic [PSC_W-1:0] acc_q;

    always_comb begin
        src_en = 1'b0;
        expo   = '0;
        unique case (tick_src_e'(src_sel))
            SRC_BUS: begin
                src_en = ce_bus;
                if (div_sel == DW'(0))      expo = '0;
                else if (div_sel == DW'(1)) expo = DW'(1);
                else                        expo = DW'(3);
            end
            SRC_SLOW: begin
                src_en = ce_slow;
                expo   = div_sel;
            end
            SRC_CASC: src_en = casc_in;
            default:  src_en = 1'b0;
        endcase
    end

    assign mask = PSC_W'((32'd1 << expo) - 32'd1);
    assign tick = run && src_en && ((acc_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             acc_q <= '0;
        else if (clr)           acc_q <= '0;
        else if (run && src_en) acc_q <= acc_q + 1'b1;
    end
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          duty_wr,
    input  logic [CW-1:0] duty_val,
    input  logic          counting,
    input  logic          reload,
    input  logic          step,
    input  logic          sq_en,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    mode,
    output logic          pin,
    output logic          evt
);
    logic [CW-1:0] buf_q, act_q, elapsed;
    logic [CW:0]   cmp_eff, el_ext;
    logic          raw;

    assign elapsed = per - cnt;
    assign el_ext  = {1'b0, elapsed};
    assign cmp_eff = sq_en ? (({1'b0, per} + (CW+1)'(2)) >> 1) : {1'b0, act_q};
    assign raw     = counting && (el_ext >= cmp_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
            evt   <= 1'b0;
        end else begin
            if (duty_wr) buf_q <= duty_val;
            if (reload) act_q <= buf_q;
            else if (duty_wr && !counting) act_q <= duty_val;
            evt <= step && ((el_ext + (CW+1)'(1)) == cmp_eff);
        end
    end

    always_comb begin
        unique case (pin_mode_e'(mode))
            PM_LOW:  pin = raw;
            PM_HIGH: pin = !raw;
            default: pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int CW       = 16,
    parameter int PSC_W    = 7,
    parameter int SYNC_LAT = 3,
    localparam int DW = $clog2(PSC_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    src_sel,
    input  logic [DW-1:0] div_sel,
    input  logic          ce_bus,
    input  logic          ce_slow,
    input  logic          casc_in,
    input  logic          sq_mode,
    input  logic [1:0]    mode_a,
    input  logic [1:0]    mode_b,
    output logic          pin_a,
    output logic          pin_b,
    output logic          uf_evt,
    output logic          cmp_a_evt,
    output logic          cmp_b_evt,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          sync_busy
);
    logic [CW-1:0] per_q, cnt_q;
    logic          uf_q, tick, per_wr, cmd_wr, rld_req, preempt, uf_now, step;
    logic [1:0]    pins, evts;

    assign per_wr  = wr_en && (wr_addr == ADR_PERIOD);
    assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
    assign rld_req = cmd_wr && wr_data[2];
    assign preempt = per_wr || rld_req;
    assign uf_now  = tick && (cnt_q == '0) && !preempt;
    assign step    = tick && (cnt_q != '0) && !preempt;

    dtmr_ctrl #(.SYNC_LAT(SYNC_LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (cmd_wr && wr_data[0]),
        .stop_req  (cmd_wr && wr_data[1]),
        .counting  (running),
        .sync_busy (sync_busy)
    );

    dtmr_psc #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .div_sel (div_sel),
        .ce_bus  (ce_bus),
        .ce_slow (ce_slow),
        .casc_in (casc_in),
        .run     (running),
        .clr     (preempt),
        .tick    (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '1;
            cnt_q <= '1;
            uf_q  <= 1'b0;
        end else begin
            uf_q <= uf_now;
            if (per_wr) begin
                per_q <= wr_data;
                cnt_q <= wr_data;
            end else if (rld_req) begin
                cnt_q <= per_q;
            end else if (tick) begin
                cnt_q <= (cnt_q == '0) ? per_q : cnt_q - 1'b1;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_chan
        dtmr_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .duty_wr  (wr_en && (wr_addr == ((g == 0) ? ADR_DUTY_A : ADR_DUTY_B))),
            .duty_val (wr_data),
            .counting (running),
            .reload   (uf_now),
            .step     (step),
            .sq_en    (sq_mode),
            .per      (per_q),
            .cnt      (cnt_q),
            .mode     ((g == 0) ? mode_a : mode_b),
            .pin      (pins[g]),
            .evt      (evts[g])
        );
    end

    assign pin_a     = pins[0];
    assign pin_b     = pins[1];
    assign cmp_a_evt = evts[0];
    assign cmp_b_evt = evts[1];
    assign uf_evt    = uf_q;
    assign count     = cnt_q;
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count,
    input logic [CW-1:0] per,
    input logic          uf_evt,
    input logic          running,
    input logic          sync_busy,
    input logic          pin_a,
    input logic          cmp_a_evt,
    input logic [1:0]    mode_a
);
    p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |-> (count == per));

    p_uf_from_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |-> ($past(count) == '0));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= per);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ((count == $past(count) - 1'b1) || (count == per)));

    p_arm_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(sync_busy, 3));

    p_cmp_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a_evt && running && (mode_a == 2'd1) && ($past(mode_a) == 2'd1))
        |-> (pin_a && !$past(pin_a)));
endmodule

bind dtmr_top dtmr_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .per       (per_q),
    .uf_evt    (uf_evt),
    .running   (running),
    .sync_busy (sync_busy),
    .pin_a     (pin_a),
    .cmp_a_evt (cmp_a_evt),
    .mode_a    (mode_a)
);

// File: tb/tb_dtmr_top.sv
module tb_dtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  src_sel = '0;
    logic [2:0]  div_sel = '0;
    logic        ce_bus = 1'b1;
    logic        ce_slow = 1'b0;
    logic        casc_in = 1'b0;
    logic        sq_mode = 1'b0;
    logic [1:0]  mode_a = 2'd1;
    logic [1:0]  mode_b = 2'd1;
    logic        pin_a, pin_b, uf_evt, cmp_a_evt, cmp_b_evt, running, sync_busy;
    logic [15:0] count;
    int          n_chk = 0;
    int          n_err = 0;
    int          cc = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        cc      <= (cc == 2) ? 0 : cc + 1;
        casc_in <= (cc == 0);
    end

    dtmr_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_sel(src_sel), .div_sel(div_sel), .ce_bus(ce_bus), .ce_slow(ce_slow),
        .casc_in(casc_in), .sq_mode(sq_mode), .mode_a(mode_a), .mode_b(mode_b),
        .pin_a(pin_a), .pin_b(pin_b), .uf_evt(uf_evt), .cmp_a_evt(cmp_a_evt),
        .cmp_b_evt(cmp_b_evt), .count(count), .running(running), .sync_busy(sync_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; captured on the next posedge, returns at the following negedge
    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_uf();
        int k = 0;
        @(negedge clk);
        while (!uf_evt && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic measure(input bit sync, output int n, output int h, output int hb, output int e);
        if (sync) wait_uf();
        n = 0; h = 0; hb = 0; e = 0;
        do begin
            if (pin_a) h++;
            if (pin_b) hb++;
            if (cmp_a_evt) e++;
            n++;
            @(negedge clk);
        end while (!uf_evt && n < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n, h, hb, e, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset count", int'(count), 65535);
        chk("R10 reset running", int'(running), 0);
        chk("R10 reset busy", int'(sync_busy), 0);
        chk("R1 reset uf", int'(uf_evt), 0);
        chk("R9 idle pin_a low", int'(pin_a), 0);
        // idle levels for every pin mode
        mode_b = 2'd2; #1;
        chk("R9 idle pin_b mode2 high", int'(pin_b), 1);
        mode_a = 2'd0; #1;
        chk("R9 mode0 pin low", int'(pin_a), 0);
        mode_a = 2'd3; #1;
        chk("R9 mode3 pin low", int'(pin_a), 0);
        mode_a = 2'd1; mode_b = 2'd1;
        @(negedge clk);

        // R2 while idle and R10 start latency
        wr(2'd0, 50);
        chk("R2 idle period load", int'(count), 50);
        wr(2'd3, 1);
        chk("R10 start busy", int'(sync_busy), 1);
        chk("R10 start not running", int'(running), 0);
        @(negedge clk); @(negedge clk);
        chk("R10 still arming", int'(running), 0);
        chk("R10 no count while arming", int'(count), 50);
        @(negedge clk);
        chk("R10 running after 3", int'(running), 1);
        chk("R10 busy cleared", int'(sync_busy), 0);
        chk("R10 count held", int'(count), 50);
        @(negedge clk);
        chk("R1 first decrement", int'(count), 49);

        // R10 stop latency: counting continues while stop is pending
        wr(2'd3, 2);
        c0 = int'(count);
        chk("R10 stop busy", int'(sync_busy), 1);
        chk("R10 halt still running", int'(running), 1);
        @(negedge clk);
        chk("R10 counts during halt", int'(count), c0 - 1);
        @(negedge clk); @(negedge clk);
        chk("R10 stopped after 3", int'(running), 0);
        chk("R10 final count", int'(count), c0 - 3);
        @(negedge clk);
        chk("R10 frozen", int'(count), c0 - 3);

        // R10 stop ignored while arming
        wr(2'd3, 1);
        wr(2'd3, 2);
        @(negedge clk); @(negedge clk);
        chk("R10 stop during arm ignored", int'(running), 1);

        // R3 reload command, R2 period write while running
        repeat (3) @(negedge clk);
        wr(2'd3, 4);
        chk("R3 reload to period", int'(count), 50);
        repeat (2) @(negedge clk);
        wr(2'd0, 40);
        chk("R2 running period load", int'(count), 40);

        // R1 R5 R6 sweep over small periods and every compare value
        for (int r = 0; r <= 6; r++) begin
            for (int c = 0; c <= r + 2; c++) begin
                wr(2'd1, c);
                wr(2'd0, r);
                measure(1'b1, n, h, hb, e);
                chk("R1 period length", n, r + 1);
                if (c == 0)
                    chk("R6 zero compare all high", h, r + 1);
                else if (c > r)
                    chk("R6 large compare all low", h, 0);
                else
                    chk("R5 high time", h, r + 1 - c);
                chk((c >= 1 && c <= r) ? "R5 compare event" : "R6 no compare event",
                    e, (c >= 1 && c <= r) ? 1 : 0);
            end
        end

        // R8 square mode, R9 inverted output on pin B
        sq_mode = 1'b1; mode_b = 2'd2;
        for (int r = 0; r <= 7; r++) begin
            wr(2'd0, r);
            measure(1'b1, n, h, hb, e);
            chk("R8 square low-start high time", h, (r + 1) / 2);
            chk("R9 inverted pin high time", hb, (r + 2) / 2);
        end
        mode_a = 2'd0;
        measure(1'b1, n, h, hb, e);
        chk("R9 mode0 while running", h, 0);
        mode_a = 2'd3;
        measure(1'b1, n, h, hb, e);
        chk("R9 mode3 while running", h, 0);
        mode_a = 2'd1; mode_b = 2'd1; sq_mode = 1'b0;

        // R7 duty written mid-period
        wr(2'd1, 2);
        wr(2'd0, 9);
        wait_uf();
        n = 0; h = 0;
        do begin
            if (pin_a) h++;
            if (n == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd5; end
            else wr_en = 1'b0;
            n++;
            @(negedge clk);
        end while (!uf_evt && n < 5000);
        wr_en = 1'b0;
        chk("R7 old duty kept this period", h, 8);
        measure(1'b0, n, h, hb, e);
        chk("R7 new duty after underflow", h, 5);
        // R7 duty written on the underflow tick
        repeat (9) @(negedge clk);
        wr(2'd1, 7);
        chk("R1 underflow with duty write", int'(uf_evt), 1);
        measure(1'b0, n, h, hb, e);
        chk("R7 write at underflow waits", h, 5);
        measure(1'b0, n, h, hb, e);
        chk("R7 applied one period later", h, 3);
        // R7 duty written while stopped is immediate
        wr(2'd3, 2);
        repeat (4) @(negedge clk);
        wr(2'd0, 9);
        wr(2'd1, 4);
        wr(2'd3, 1);
        while (!running) @(negedge clk);
        measure(1'b0, n, h, hb, e);
        chk("R7 idle duty immediate", h, 6);
        chk("R1 first period length", n, 10);

        // R4 prescaler and source selection
        wr(2'd0, 3);
        div_sel = 3'd1;
        wait_uf(); measure(1'b1, n, h, hb, e);
        chk("R4 bus div2", n, 8);
        div_sel = 3'd2;
        wait_uf(); measure(1'b1, n, h, hb, e);
        chk("R4 bus div_sel2 maps to 8", n, 32);
        div_sel = 3'd3;
        wait_uf(); measure(1'b1, n, h, hb, e);
        chk("R4 bus div8", n, 32);
        src_sel = 2'd1; ce_slow = 1'b1; div_sel = 3'd2;
        wait_uf(); measure(1'b1, n, h, hb, e);
        chk("R4 slow div4", n, 16);
        div_sel = 3'd7;
        wait_uf(); measure(1'b1, n, h, hb, e);
        chk("R4 slow div128", n, 512);
        src_sel = 2'd2; div_sel = 3'd5;
        wait_uf(); measure(1'b1, n, h, hb, e);
        chk("R4 cascade ignores divider", n, 12);
        src_sel = 2'd3;
        c0 = int'(count);
        repeat (20) @(negedge clk);
        chk("R4 no source no count", int'(count), c0);
        src_sel = 2'd0; div_sel = 3'd0; ce_slow = 1'b0;

        // R11 period write and reload on the underflow tick
        wr(2'd0, 4);
        wait_uf();
        repeat (4) @(negedge clk);
        wr(2'd0, 6);
        chk("R11 period write suppresses underflow", int'(uf_evt), 0);
        chk("R11 period write wins", int'(count), 6);
        measure(1'b0, n, h, hb, e);
        chk("R11 next period length", n, 7);
        repeat (6) @(negedge clk);
        wr(2'd3, 4);
        chk("R11 reload suppresses underflow", int'(uf_evt), 0);
        chk("R11 reload wins", int'(count), 6);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule